// File: doc/BRIEF.md
# Floppy Write-Stream Encoder (FM / MFM / M2FM with precompensation)

This block turns a stream of bytes into the pulse train that drives a floppy write head. Bytes come in over a valid/ready port and are shifted out MSB first. Each data bit takes one bit cell. A cell has two halves: a clock slot and then a data slot. A slot either holds a flux-change pulse or stays empty. The block supports three encodings: single-density FM, and two double-density codes, MFM and M2FM. All bit-cell timing comes from the crystal clock `clk`. A rate bit halves the data rate without any change to the clock.

In double density the block can apply write precompensation. A pulse that sits next to a close neighbour on one side and a distant one on the other is moved by a fixed interval, away from the close neighbour. This offsets the peak shift that the media causes on read-back. The decision needs the two slots on each side of the pulse, so slots run through a five-slot window before they are emitted.

Back-pressure rules: `in_ready` asks for one byte per request window. The source may hold `in_valid` high for as long as it likes. A byte moves only on a cycle where both `in_valid` and `in_ready` are high. After one byte is taken, `in_ready` stays low until the next window. If a window closes with no byte taken, the encoder writes a byte of zero data and the stream keeps its timing. The encoding, rate and precompensation inputs are meant to change only while writing is disabled.

Top module: `flo_write_encoder`

## Requirements
- R1: `enc_sel[1]`=1 selects FM, and `enc_sel[0]` is then ignored. `enc_sel`=00 selects MFM. `enc_sel`=01 selects M2FM. MFM and M2FM are the double-density codes.
- R2: One slot (half a bit cell) lasts H crystal cycles, and H = HALF_BASE × 2^(FM) × 2^(not `rate_hi`). With the default HALF_BASE of 8, a bit takes 16 cycles in double density with `rate_hi`=1 (500 kbit/s from 8 MHz), 32 cycles in FM with `rate_hi`=1, and twice as many in each case with `rate_hi`=0.
- R3: In FM every clock slot holds a pulse. The data slot holds a pulse exactly when the data bit is 1.
- R4: In MFM the data slot holds a pulse when the bit is 1. The clock slot holds a pulse only when the previous bit and the current bit are both 0. Before the first cell, the previous bit counts as 0.
- R5: In M2FM the data slots follow the MFM rule. The clock slot holds a pulse only when the previous bit and the current bit are both 0 and the previous clock slot held no pulse. Before the first cell, the previous clock slot counts as empty.
- R6: Number the slots from s=0, the clock slot of the first cell after writing is enabled. A pulse in slot s appears as `wr_pulse` high for exactly one cycle. It is observed after rising edge number (s+3)·H + off + 1, counting the first edge with writing enabled as edge 1. The nominal offset is off = H/2.
- R7: When `precomp_en`=1 and a double-density code is selected, the offset changes in two cases. If slot s−2 holds a pulse and slot s+2 does not, the pulse is late: off = H − H/4. If slot s+2 holds a pulse and slot s−2 does not, the pulse is early: off = H/4. The shift H/4 equals 2T. In FM, or with `precomp_en`=0, every pulse uses off = H/2.
- R8: Writing is enabled only while `write_mode` and `gate_en` are both 1. While it is disabled, `wr_pulse` and `in_ready` stay low and the encoder returns to its start state. `in_ready` and `wr_pulse` are 0 during reset.
- R9: `in_ready` rises in the first enabled cycle, and again when the last bit of a byte begins its cell. It stays high until a byte is accepted or until the cycle before that cell ends. The first byte accepted forms cells 0 to 7, and each later byte follows on directly, MSB first.
- R10: If a request window closes with no byte accepted, the next eight cells carry data 0. They still get clock pulses under the rules of the selected code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock; all timing derives from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Byte to be written, MSB first |
| in_valid | input | 1 | Source offers `in_data` |
| in_ready | output | 1 | Encoder requests a byte (request window) |
| enc_sel | input | 2 | Encoding select: 1x FM, 00 MFM, 01 M2FM |
| rate_hi | input | 1 | 1 = full rate, 0 = half rate |
| precomp_en | input | 1 | Enables early/late shift in double density |
| write_mode | input | 1 | Write direction selected |
| gate_en | input | 1 | Write gate enable |
| wr_pulse | output | 1 | One-cycle write pulse per flux change |

## Verification
Early and late shifts appear only for particular neighbour patterns, two slots away on each side. In M2FM they also depend on whether the previous clock slot was written. The bench therefore picks byte values that produce isolated pulses, pulse pairs and runs of zeros, and it runs those values at the slow rate so the shift spans several cycles. The hardest case is a starved request window. The stimulus holds `in_valid` low for one whole window between two bytes, so that a zero byte is inserted, and then releases the next byte inside the following window. The expected pulse times for every slot come from a model of the slot rules that runs in the bench.

// File: rtl/flo_wr_pkg.sv
package flo_wr_pkg;
  typedef enum logic [1:0] {
    ENC_MFM  = 2'd0,
    ENC_M2FM = 2'd1,
    ENC_FM   = 2'd2
  } enc_e;

  // the high select bit forces single density; the low bit picks the double-density variant
  function automatic enc_e decode_enc(input logic [1:0] sel);
    if (sel[1]) return ENC_FM;
    if (sel[0]) return ENC_M2FM;
    return ENC_MFM;
  endfunction
endpackage

// File: rtl/flo_cell_timer.sv
module flo_cell_timer #(
  parameter int HALF_BASE = 8,
  parameter int CW        = $clog2(HALF_BASE * 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          is_fm,
  input  logic          rate_hi,
  output logic [CW-1:0] phase,
  output logic [CW:0]   half,
  output logic          slot_end,
  output logic          data_slot
);
  logic [1:0] sh_amt;

  always_comb begin
    sh_amt   = {1'b0, is_fm} + {1'b0, ~rate_hi};
    half     = (CW + 1)'(HALF_BASE) << sh_amt;
    slot_end = ({1'b0, phase} == half - 1'b1);
  end

  // data_slot starts at 1 so the first slot boundary opens a clock slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      data_slot <= 1'b1;
    end else if (!en) begin
      phase     <= '0;
      data_slot <= 1'b1;
    end else if (slot_end) begin
      phase     <= '0;
      data_slot <= ~data_slot;
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/flo_byte_feeder.sv
module flo_byte_feeder #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cell_start,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          next_bit
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic [BW-1:0] bidx;
  logic [DW-1:0] rest;
  logic [DW-1:0] pend;
  logic          pend_v;
  logic          last;
  logic [DW-1:0] src;

  always_comb begin
    last     = (bidx == BW'(DW - 1));
    src      = pend_v ? pend : '0;
    next_bit = last ? src[DW-1] : rest[DW-1];
    // the window closes one cycle early so a late accept never races the load
    in_ready = en && last && !pend_v && !cell_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bidx   <= BW'(DW - 1);
      rest   <= '0;
      pend   <= '0;
      pend_v <= 1'b0;
    end else if (!en) begin
      bidx   <= BW'(DW - 1);
      rest   <= '0;
      pend   <= '0;
      pend_v <= 1'b0;
    end else begin
      if (in_valid && in_ready) begin
        pend   <= in_data;
        pend_v <= 1'b1;
      end
      if (cell_start) begin
        if (last) begin
          rest   <= {src[DW-2:0], 1'b0};
          pend_v <= 1'b0;
          bidx   <= '0;
        end else begin
          rest <= {rest[DW-2:0], 1'b0};
          bidx <= bidx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flo_slot_encoder.sv
module flo_slot_encoder
  import flo_wr_pkg::*;
#(
  parameter int WIN = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  enc_e           enc,
  input  logic           slot_end,
  input  logic           data_slot,
  input  logic           next_bit,
  output logic [WIN-1:0] win
);
  logic cur_d;
  logic prev_c;
  logic clk_bit;

  always_comb begin
    unique case (enc)
      ENC_FM:   clk_bit = 1'b1;
      ENC_M2FM: clk_bit = !cur_d && !next_bit && !prev_c;
      default:  clk_bit = !cur_d && !next_bit;
    endcase
  end

  // win[0] is the newest slot and win[WIN-1] the oldest
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win    <= '0;
      cur_d  <= 1'b0;
      prev_c <= 1'b0;
    end else if (!en) begin
      win    <= '0;
      cur_d  <= 1'b0;
      prev_c <= 1'b0;
    end else if (slot_end) begin
      if (data_slot) begin
        win    <= {win[WIN-2:0], clk_bit};
        prev_c <= clk_bit;
        cur_d  <= next_bit;
      end else begin
        win <= {win[WIN-2:0], cur_d};
      end
    end
  end
endmodule

// File: rtl/flo_precomp_out.sv
module flo_precomp_out #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          is_dd,
  input  logic          pc_en,
  input  logic [CW:0]   half,
  input  logic [CW-1:0] phase,
  input  logic          prev_s,
  input  logic          cur_s,
  input  logic          next_s,
  output logic          wr_pulse
);
  logic [CW:0] quarter;
  logic [CW:0] off;
  logic        shift_ok;

  always_comb begin
    quarter  = half >> 2;
    shift_ok = is_dd && pc_en;
    if (shift_ok && prev_s && !next_s)      off = half - quarter;
    else if (shift_ok && !prev_s && next_s) off = quarter;
    else                                    off = half >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  wr_pulse <= 1'b0;
    else         wr_pulse <= en && cur_s && ({1'b0, phase} == off);
  end
endmodule

// File: rtl/flo_write_encoder.sv
module flo_write_encoder
  import flo_wr_pkg::*;
#(
  parameter int HALF_BASE = 8,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    enc_sel,
  input  logic          rate_hi,
  input  logic          precomp_en,
  input  logic          write_mode,
  input  logic          gate_en,
  output logic          wr_pulse
);
  localparam int CW  = $clog2(HALF_BASE * 4);
  localparam int WIN = 5;
  localparam int MID = WIN / 2;

  enc_e           enc;
  logic           en;
  logic           is_fm;
  logic [CW-1:0]  phase;
  logic [CW:0]    half;
  logic           slot_end;
  logic           data_slot;
  logic           next_bit;
  logic [WIN-1:0] win;

  always_comb begin
    enc   = decode_enc(enc_sel);
    en    = write_mode && gate_en;
    is_fm = (enc == ENC_FM);
  end

  flo_cell_timer #(.HALF_BASE(HALF_BASE), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .is_fm(is_fm), .rate_hi(rate_hi),
    .phase(phase), .half(half), .slot_end(slot_end), .data_slot(data_slot)
  );

  flo_byte_feeder #(.DW(DW)) u_feed (
    .clk(clk), .rst_n(rst_n), .en(en), .cell_start(slot_end && data_slot),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .next_bit(next_bit)
  );

  flo_slot_encoder #(.WIN(WIN)) u_enc (
    .clk(clk), .rst_n(rst_n), .en(en), .enc(enc), .slot_end(slot_end),
    .data_slot(data_slot), .next_bit(next_bit), .win(win)
  );

  flo_precomp_out #(.CW(CW)) u_out (
    .clk(clk), .rst_n(rst_n), .en(en), .is_dd(!is_fm), .pc_en(precomp_en),
    .half(half), .phase(phase), .prev_s(win[WIN-1]), .cur_s(win[MID]),
    .next_s(win[0]), .wr_pulse(wr_pulse)
  );
endmodule

// File: rtl/flo_write_encoder_chk.sv
module flo_write_encoder_chk #(
  parameter int HALF_BASE = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] enc_sel,
  input logic       rate_hi,
  input logic       write_mode,
  input logic       gate_en,
  input logic       in_valid,
  input logic       in_ready,
  input logic       wr_pulse
);
  logic        en;
  int          half_c;
  logic [15:0] gap;
  logic        seen;

  always_comb begin
    en     = write_mode && gate_en;
    half_c = HALF_BASE << ((enc_sel[1] ? 1 : 0) + (rate_hi ? 0 : 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (!en) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (wr_pulse) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 1'b1;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_pulse |=> !wr_pulse); // R6
  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !wr_pulse); // R8
  AST_GATED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !in_ready); // R8
  AST_ONE_PER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> !in_ready); // R9
  AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (wr_pulse && seen) |-> (int'(gap) + 1 >= half_c)); // R7
endmodule

bind flo_write_encoder flo_write_encoder_chk #(.HALF_BASE(HALF_BASE)) u_chk (.*);

// File: tb/sim_flo_write_encoder.sv
module sim_flo_write_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int HB         = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] enc_sel = 2'b00;
  logic       rate_hi = 1'b1;
  logic       precomp_en = 1'b0;
  logic       write_mode = 1'b0;
  logic       gate_en = 1'b0;
  logic       wr_pulse;

  int    vecs = 0;
  int    bad = 0;
  int    n = 0;
  int    hs = 0;
  int    exp_q[$];
  string tag = "R8";
  bit    slot_a[0:127];
  bit    ready_seen = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flo_write_encoder #(.HALF_BASE(HB), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .enc_sel(enc_sel), .rate_hi(rate_hi),
    .precomp_en(precomp_en), .write_mode(write_mode), .gate_en(gate_en),
    .wr_pulse(wr_pulse)
  );

  always @(posedge clk) begin
    if (write_mode && gate_en) begin
      n <= n + 1;
      if (in_valid && in_ready) hs <= hs + 1;
    end else begin
      n  <= 0;
      hs <= 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: every pulse is matched against the head of the scoreboard queue
  always @(negedge clk) begin
    if (in_ready) ready_seen = 1'b1;
    if (rst_n && wr_pulse) begin
      if (exp_q.size() == 0) check(1'b0, tag, n, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(e == n, tag, n, e);
      end
    end
  end

  // driver: build the slot model, push expected pulse times, then stream the bytes
  task automatic run_case(input string t, input logic [1:0] es, input logic rh,
                          input logic pc, input logic [31:0] bytes, input int nb,
                          input bit gap);
    int h, ncb, ncell, ns, endn;
    bit pd, pcl, fm, dd;
    logic [7:0] cb [0:4];
    @(negedge clk);
    write_mode = 1'b0; gate_en = 1'b0; in_valid = 1'b0;
    enc_sel = es; rate_hi = rh; precomp_en = pc; tag = t;
    fm = es[1]; dd = !es[1];
    h = HB << ((fm ? 1 : 0) + (rh ? 0 : 1));
    ncb = 0;
    for (int k = 0; k < nb; k++) begin
      if (gap && k == 1) begin cb[ncb] = 8'h00; ncb++; end
      cb[ncb] = bytes[8*(3-k) +: 8]; ncb++;
    end
    ncell = 8 * ncb + 2;
    pd = 1'b0; pcl = 1'b0;
    for (int i = 0; i < ncell; i++) begin
      bit d, c;
      d = (i / 8 < ncb) ? cb[i/8][7 - (i % 8)] : 1'b0;
      if (fm) c = 1'b1;
      else c = !pd && !d && (es[0] ? !pcl : 1'b1);
      slot_a[2*i] = c; slot_a[2*i+1] = d;
      pcl = c; pd = d;
    end
    ns = 2 * ncell - 2;
    for (int s = 0; s < ns; s++) begin
      if (slot_a[s]) begin
        bit pv, nx;
        int off;
        pv = (s >= 2) ? slot_a[s-2] : 1'b0;
        nx = slot_a[s+2];
        off = h / 2;
        if (dd && pc && pv && !nx) off = h - h / 4;
        else if (dd && pc && !pv && nx) off = h / 4;
        exp_q.push_back((s + 3) * h + off + 1);
      end
    end
    endn = (ns + 3) * h;
    while (1) begin
      int idx;
      idx = hs;
      if (idx < nb && !(gap && idx == 1 && n < 18 * h)) begin
        in_valid = 1'b1; in_data = bytes[8*(3-idx) +: 8];
      end else begin
        in_valid = 1'b0;
      end
      write_mode = 1'b1; gate_en = 1'b1;
      @(negedge clk);
      if (n >= endn) break;
    end
    gate_en = 1'b0; in_valid = 1'b0;
    check(hs == nb, "R9", hs, nb);
    repeat (4) @(negedge clk);
    while (exp_q.size() > 0) check(1'b0, tag, -1, exp_q.pop_front());
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R8", int'(in_ready), 0);
    check(wr_pulse == 1'b0, "R8", int'(wr_pulse), 0);
    rst_n = 1'b1;
    // R1 R3 R2: FM at full rate, low select bit set to show it is ignored
    run_case("R1 R3 R2", 2'b11, 1'b1, 1'b0, 32'hA5FF0000, 2, 1'b0);
    // R4 R10: MFM without precompensation, trailing zero fill
    run_case("R4 R6 R10", 2'b00, 1'b1, 1'b0, 32'h4EC20000, 2, 1'b0);
    // R7: MFM with early and late shifts
    run_case("R4 R7", 2'b00, 1'b1, 1'b1, 32'h4EC2A100, 3, 1'b0);
    // R5 R7 R2: M2FM at half rate with precompensation
    run_case("R5 R7 R2", 2'b01, 1'b0, 1'b1, 32'h1A00E700, 3, 1'b0);
    // R10 R9: starved request window between two bytes
    run_case("R10 R9 R7", 2'b00, 1'b0, 1'b1, 32'hF03C8100, 3, 1'b1);
    // R7: precompensation must not move FM pulses
    run_case("R7 R3", 2'b10, 1'b0, 1'b1, 32'h96000000, 1, 1'b0);
    // R8: gate low with write selected, then write mode low with gate set
    tag = "R8";
    @(negedge clk);
    ready_seen = 1'b0; in_valid = 1'b1; in_data = 8'hFF;
    write_mode = 1'b1; gate_en = 1'b0;
    repeat (200) @(negedge clk);
    write_mode = 1'b0; gate_en = 1'b1;
    repeat (200) @(negedge clk);
    check(ready_seen == 1'b0, "R8", int'(ready_seen), 0);
    check(hs == 0, "R8", hs, 0);
    in_valid = 1'b0; gate_en = 1'b0;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule